// File: doc/BRIEF.md
# SPI Serial Clock and Select Sequencer

This block sits at the front of a SPI flash master. It drives the serial clock, the active-low chip select and a pair of one-cycle strobes that tell the data path when to shift out the next bit and when to capture the incoming bit. All timing is taken from the reference clock. A power-of-two divider sets the bit rate, and two configuration bits set the clock polarity and phase. A transfer is driven one byte at a time. After each byte the sequencer looks at the transmit-data-available input. If it is high, the sequencer runs another byte without a gap; otherwise it closes the frame. The bit counting, FIFOs and shift registers live outside this block.

Software writes a 32-bit configuration word and a one-bit enable. The sequencer starts a frame when it is enabled, master operation is selected and transmit data is waiting. In manual start mode it also waits for a write that carries the start bit. The start bit is never stored. In forced-select mode the select pin follows a configuration bit directly, and the sequencer stops driving it.

Top module: `spi_clk_cs_seq`

## Requirements
- R1: After reset the configuration readback is 0, the controller is off, `cs_n` is 1, `sclk` is 0 and neither strobe nor `byte_end` is high.
- R2: With divisor code n in config bits [5:3], every half period of `sclk` lasts 2^n reference cycles. Code 0 gives divide-by-2 and code 7 gives divide-by-256.
- R3: Config bit 1 (polarity) sets the level of `sclk` whenever no frame is running. A write of this bit changes the idle level in the very next cycle.
- R4: Config bit 2 (phase) sets which edges carry which strobe. With phase 0, each leading edge gives `sample_stb` and each trailing edge gives `shift_stb`. With phase 1 the two are swapped.
- R5: Each byte has 16 `sclk` edges, 8 sample strobes and 8 shift strobes, and ends with one `byte_end` pulse. The two strobes are never high together.
- R6: With automatic select, `cs_n` goes low 2·2^n cycles before the first clock edge and goes high 2^n cycles after the last edge. A frame of k back-to-back bytes therefore holds `cs_n` low for (16k+2)·2^n cycles. The next byte runs only if `tx_avail` is high at the final edge of the current byte.
- R7: When config bit 15 (manual start) is set, pending data alone starts nothing. A frame begins only on a configuration write with bit 16 set.
- R8: Config bit 16 reads back as 0 at all times, and the other written bits read back unchanged.
- R9: When config bit 14 (forced select) is set, `cs_n` equals config bit 10 whatever the sequencer is doing.
- R10: The controller runs only while enable bit 0 and config bit 0 (master) are both 1. Clearing either one during a frame ends it: in the next cycle `cs_n` is 1 and `sclk` is back at its idle level, and no new frame starts while either is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write data |
| tx_avail | input | 1 | Transmit data is waiting |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| shift_stb | output | 1 | Launch the next outgoing bit |
| sample_stb | output | 1 | Capture the incoming bit |
| byte_end | output | 1 | One pulse when a byte's last edge is made |

## Verification
The hardest case to reach is a frame cut off in the middle of a byte. The disable has to land while `sclk` sits at its non-idle level, so that a wrong recovery would be visible. The stimulus watches `sclk` and clears the enable on a cycle just after the third toggle. It then checks on the next cycle that the select and clock have returned to idle. Back-to-back bytes are a second hard case: `tx_avail` is dropped only after the first `byte_end` has been seen, so the decision between continuing and closing is made at the very last edge.

// File: rtl/spi_clk_cs_seq.sv
module spi_clk_cs_seq #(
  parameter int DIV_W     = 3,
  parameter int BYTE_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        en_we,
  input  logic        en_wdata,
  input  logic        tx_avail,
  output logic        sclk,
  output logic        cs_n,
  output logic        shift_stb,
  output logic        sample_stb,
  output logic        byte_end
);
  localparam int CNT_W    = (1 << DIV_W) - 1;
  localparam int EDGES    = 2 * BYTE_BITS;
  localparam int EDGE_W   = $clog2(EDGES);
  localparam int MST_B    = 0;
  localparam int CPOL_B   = 1;
  localparam int CPHA_B   = 2;
  localparam int BAUD_LSB = 3;
  localparam int CSV_B    = 10;
  localparam int FCS_B    = 14;
  localparam int MAN_B    = 15;
  localparam int START_B  = 16;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_RUN, S_TAIL} seq_t;

  seq_t              state;
  logic [31:0]       cfg_q;
  logic              en_q;
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] eidx;
  logic              ph;
  logic              shift_q, sample_q, bend_q;

  logic             cpol, cpha, force_cs, man_en, is_idle;
  logic [DIV_W-1:0] baud;
  logic [CNT_W-1:0] half_m1;
  logic             run_ok, kill, start_ok, go;

  assign cpol     = cfg_q[CPOL_B];
  assign cpha     = cfg_q[CPHA_B];
  assign force_cs = cfg_q[FCS_B];
  assign man_en   = cfg_q[MAN_B];
  assign baud     = cfg_q[BAUD_LSB +: DIV_W];
  assign is_idle  = (state == S_IDLE);
  assign half_m1  = {CNT_W{1'b1}} >> (DIV_W'(CNT_W) - baud);

  assign run_ok   = en_q & cfg_q[MST_B];
  assign kill     = !run_ok || (en_we && !en_wdata) || (cfg_we && !cfg_wdata[MST_B]);
  assign start_ok = man_en ? (cfg_we & cfg_wdata[START_B]) : 1'b1;
  assign go       = run_ok && tx_avail && start_ok && !kill;

  assign cfg_rdata  = cfg_q;
  assign sclk       = cpol ^ ph;
  assign cs_n       = force_cs ? cfg_q[CSV_B] : is_idle;
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;
  assign byte_end   = bend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg_q    <= '0;
      en_q     <= 1'b0;
      cnt      <= '0;
      eidx     <= '0;
      ph       <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      bend_q   <= 1'b0;
    end else begin
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      bend_q   <= 1'b0;
      if (cfg_we) cfg_q <= cfg_wdata & ~(32'h1 << START_B);
      if (en_we)  en_q  <= en_wdata;
      if (kill && !is_idle) begin
        state <= S_IDLE;
        ph    <= 1'b0;
        eidx  <= '0;
      end else begin
        case (state)
          S_IDLE: if (go) begin
            state <= S_LEAD;
            cnt   <= half_m1;
            eidx  <= '0;
            ph    <= 1'b0;
          end
          S_LEAD: if (cnt == '0) begin
            state <= S_RUN;
            cnt   <= half_m1;
          end else cnt <= cnt - 1'b1;
          S_RUN: if (cnt == '0) begin
            cnt  <= half_m1;
            ph   <= ~ph;
            eidx <= eidx + 1'b1;
            if (eidx[0] == cpha) sample_q <= 1'b1;
            else                 shift_q  <= 1'b1;
            if (eidx == EDGE_W'(EDGES - 1)) begin
              bend_q <= 1'b1;
              eidx   <= '0;
              if (!tx_avail) state <= S_TAIL;
            end
          end else cnt <= cnt - 1'b1;
          S_TAIL: if (cnt == '0) state <= S_IDLE;
                  else cnt <= cnt - 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic             shift_stb,
  input logic             sample_stb,
  input logic             cfg_we,
  input logic             en_we,
  input logic             en_wdata,
  input logic             cpol,
  input logic             force_cs,
  input logic             man_en,
  input logic             is_idle,
  input logic [DIV_W-1:0] baud
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> sclk == cpol);

  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));

  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) && baud != '0 && $stable(baud) |=> !(shift_stb || sample_stb));

  a_r6_select_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) && !force_cs |-> !cs_n);

  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_wdata |=> is_idle);

  a_r7_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle && man_en && !cfg_we |=> is_idle);
endmodule

bind spi_clk_cs_seq spi_seq_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
  .shift_stb(shift_stb), .sample_stb(sample_stb),
  .cfg_we(cfg_we), .en_we(en_we), .en_wdata(en_wdata),
  .cpol(cpol), .force_cs(force_cs), .man_en(man_en),
  .is_idle(is_idle), .baud(baud)
);

// File: tb/spi_clk_cs_seq_bench.sv
module spi_clk_cs_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        en_we = 1'b0;
  logic        en_wdata = 1'b0;
  logic        tx_avail = 1'b0;
  logic        sclk, cs_n, shift_stb, sample_stb, byte_end;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cur_cfg = '0;

  localparam logic [31:0] MST = 32'h1, CPOL = 32'h2, CPHA = 32'h4;
  localparam logic [31:0] CSV = 32'h400, FCS = 32'h4000, MAN = 32'h8000, START = 32'h10000;

  always #2.5 clk = ~clk;

  spi_clk_cs_seq u_spi_clk_cs_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .en_we(en_we), .en_wdata(en_wdata),
    .tx_avail(tx_avail), .sclk(sclk), .cs_n(cs_n), .shift_stb(shift_stb),
    .sample_stb(sample_stb), .byte_end(byte_end)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v & ~START;
  endtask

  task automatic wr_en(input logic b);
    @(negedge clk);
    en_we = 1'b1; en_wdata = b;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic settle();
    tx_avail = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // Runs one frame of nbytes and reports what was seen at the pins.
  task automatic run_xfer(input int nbytes, input bit manual,
                          output int cs_cyc, output int tog, output int smp,
                          output int shf, output int bends, output int badgap,
                          output int first);
    int h = 1 << cur_cfg[5:3];
    int last = -1;
    bit seen = 0;
    logic prev = sclk;
    cs_cyc = 0; tog = 0; smp = 0; shf = 0; bends = 0; badgap = 0; first = -1;
    tx_avail = 1'b1;
    if (manual) begin cfg_we = 1'b1; cfg_wdata = cur_cfg | START; end
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (!cs_n) begin seen = 1; cs_cyc++; end
      if (sclk != prev) begin
        tog++;
        if (last >= 0 && c - last != h) badgap++;
        last = c;
      end
      prev = sclk;
      if (first < 0 && (sample_stb || shift_stb)) first = sample_stb ? 1 : 0;
      smp += int'(sample_stb);
      shf += int'(shift_stb);
      bends += int'(byte_end);
      if (seen && bends >= nbytes - 1) tx_avail = 1'b0;
      if (seen && cs_n) break;
    end
    tx_avail = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg readback", int'(cfg_rdata), 0);
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 strobes", int'(shift_stb) + int'(sample_stb) + int'(byte_end), 0);
  endtask

  task automatic t_mode0_fast();
    int cs, tg, sm, sh, be, bg, fs;
    wr_cfg(MST);
    wr_en(1'b1);
    run_xfer(1, 0, cs, tg, sm, sh, be, bg, fs);
    check("R6 cs low cycles code0", cs, 18);
    check("R5 edges per byte", tg, 16);
    check("R2 half period code0", bg, 0);
    check("R5 sample count", sm, 8);
    check("R5 shift count", sh, 8);
    check("R5 byte_end count", be, 1);
    check("R4 phase0 first is sample", fs, 1);
    check("R3 idle low", int'(sclk), 0);
    settle();
  endtask

  task automatic t_div4_two_bytes();
    int cs, tg, sm, sh, be, bg, fs;
    wr_cfg(MST | CPOL | (32'd2 << 3));
    check("R3 idle follows polarity", int'(sclk), 1);
    run_xfer(2, 0, cs, tg, sm, sh, be, bg, fs);
    check("R6 cs low two bytes code2", cs, 34 * 4);
    check("R5 edges two bytes", tg, 32);
    check("R2 half period code2", bg, 0);
    check("R5 byte_end two bytes", be, 2);
    check("R3 idle high after", int'(sclk), 1);
    settle();
  endtask

  task automatic t_div256();
    int cs, tg, sm, sh, be, bg, fs;
    wr_cfg(MST | (32'd7 << 3));
    run_xfer(1, 0, cs, tg, sm, sh, be, bg, fs);
    check("R2 cs low code7", cs, 18 * 128);
    check("R2 half period code7", bg, 0);
    check("R2 edges code7", tg, 16);
    settle();
  endtask

  task automatic t_phase1();
    int cs, tg, sm, sh, be, bg, fs;
    wr_cfg(MST | CPHA | (32'd1 << 3));
    run_xfer(1, 0, cs, tg, sm, sh, be, bg, fs);
    check("R4 phase1 first is shift", fs, 0);
    check("R4 phase1 samples", sm, 8);
    check("R6 cs low code1", cs, 36);
    settle();
  endtask

  task automatic t_manual();
    int cs, tg, sm, sh, be, bg, fs;
    int low = 0, togs = 0;
    logic prev;
    wr_cfg(MST | MAN);
    tx_avail = 1'b1;
    prev = sclk;
    repeat (50) begin
      @(negedge clk);
      low += int'(!cs_n);
      togs += int'(sclk != prev);
      prev = sclk;
    end
    check("R7 no start without start bit", low + togs, 0);
    run_xfer(1, 1, cs, tg, sm, sh, be, bg, fs);
    check("R7 start bit launches frame", cs, 18);
    check("R8 start bit reads 0", int'(cfg_rdata[16]), 0);
    check("R8 manual bit kept", int'(cfg_rdata[15]), 1);
    settle();
  endtask

  task automatic t_force();
    int low = 0, togs = 0;
    logic prev;
    wr_cfg(MST | FCS);
    check("R9 forced select low", int'(cs_n), 0);
    wr_cfg(MST | FCS | CSV);
    check("R9 forced select high", int'(cs_n), 1);
    tx_avail = 1'b1;
    prev = sclk;
    repeat (30) begin
      @(negedge clk);
      low += int'(!cs_n);
      togs += int'(sclk != prev);
      prev = sclk;
    end
    tx_avail = 1'b0;
    check("R9 select held during clocking", low, 0);
    check("R9 clock still runs", int'(togs > 0), 1);
    repeat (60) @(negedge clk);
    wr_cfg(MST);
    settle();
  endtask

  task automatic t_disable();
    int togs = 0, low = 0;
    logic prev;
    wr_cfg(MST | CPOL | (32'd1 << 3));
    tx_avail = 1'b1;
    prev = sclk;
    for (int c = 0; c < 200 && togs < 3; c++) begin
      @(negedge clk);
      togs += int'(sclk != prev);
      prev = sclk;
    end
    en_we = 1'b1; en_wdata = 1'b0;
    @(negedge clk);
    en_we = 1'b0;
    check("R10 abort releases select", int'(cs_n), 1);
    check("R10 abort idles clock", int'(sclk), 1);
    togs = 0; prev = sclk;
    repeat (40) begin
      @(negedge clk);
      low += int'(!cs_n);
      togs += int'(sclk != prev);
      prev = sclk;
    end
    check("R10 disabled stays idle", low + togs, 0);
    tx_avail = 1'b0;
    wr_en(1'b1);
    wr_cfg(32'h0);
    tx_avail = 1'b1;
    low = 0;
    repeat (40) begin
      @(negedge clk);
      low += int'(!cs_n);
    end
    check("R10 master bit clear blocks start", low, 0);
    settle();
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_fast();
    t_div4_two_bytes();
    t_div256();
    t_phase1();
    t_manual();
    t_force();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule